// File: doc/BRIEF.md
# Fetch Stall Reason Profiler

This block keeps cycle counts for the reasons a single-thread instruction fetch stage is not making progress. The fetch stage raises a stall strobe in each cycle where no thread could fetch. In that cycle the profiler picks one cause by fixed priority and bumps that cause's counter. First it looks at a pending pipeline drain, then at an empty set of active threads, and last at the current fetch status of thread 0. A separate counter records cycles in which the thread was selected but sat in the idle status.

Every counter saturates. A synchronous clear zeroes the whole bank. Counters are read one at a time through a combinational address/data port. Profiling is enabled only when the configured thread count is exactly one.

Top module: `fetch_stall_profiler`

## Requirements
- R1: When `thread_count_i` is not 1, no counter changes, whatever the other inputs are (a clear still applies).
- R2: With `stall_i` high and `drain_pend_i` high, only counter 0 (drain) increments. This holds whatever the other flags and status are.
- R3: With `stall_i` high, drain low and `no_active_i` high, only counter 1 (no active thread) increments.
- R4: With `stall_i` high and both flags low, status codes 2 blocked, 3 squashing, 4 cache response wait, 5 translation wait, 6 trap pending, 7 quiesce pending and 8 cache retry wait increment counters 2 to 8, in that same order, one counter per code.
- R5: With `stall_i` high and both flags low, status codes 0 idle, 1 running, 9 bad fetch address and 10 to 15 (unrecognised) increment no counter.
- R6: Counter 9 (idle) increments in a cycle where `stall_i` is low and the status is 0 (idle). With `stall_i` low, no other status changes any counter.
- R7: Counters are `CNT_W` bits wide (32 by default). At all-ones they hold their value instead of wrapping.
- R8: `clear_i` zeroes every counter on the next clock edge and overrides any increment in that cycle.
- R9: At most one counter increments per clock cycle.
- R10: After reset all counters read zero. `rd_data_o` shows counter `rd_addr_i` combinationally for addresses 0 to 9 and reads zero for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Fetch made no progress this cycle |
| drain_pend_i | input | 1 | Pipeline drain is pending |
| no_active_i | input | 1 | Active-thread set is empty |
| status_i | input | 4 | Fetch status code of thread 0 |
| thread_count_i | input | TW | Number of configured threads |
| clear_i | input | 1 | Synchronous clear of all counters |
| rd_addr_i | input | AW | Counter select |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
The bench drives a drain together with an empty thread set and a blocking status. A design that gave the wrong cause priority would bump the wrong counter or two counters at once. It also strobes codes that must be ignored, such as the bad-address status, the running status and the unrecognised codes 10 to 15. It repeats the stall under multi-thread configurations, where an ungated design would count. The bench also asserts clear in the same cycle as a stall, where a design that lets the increment win would leave a one behind. It holds one cause well past saturation, which a wrapping counter would fail by rolling back to small values. Reads of unused addresses must return zero.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam logic [3:0] ST_IDLE    = 4'd0;
  localparam logic [3:0] ST_RUN     = 4'd1;
  localparam logic [3:0] ST_BLOCKED = 4'd2;
  localparam logic [3:0] ST_SQUASH  = 4'd3;
  localparam logic [3:0] ST_ICWAIT  = 4'd4;
  localparam logic [3:0] ST_TLBWAIT = 4'd5;
  localparam logic [3:0] ST_TRAP    = 4'd6;
  localparam logic [3:0] ST_QUIESCE = 4'd7;
  localparam logic [3:0] ST_RETRY   = 4'd8;
  localparam logic [3:0] ST_BADADDR = 4'd9;

  localparam int NUM_CNT     = 10;
  localparam int IDX_DRAIN   = 0;
  localparam int IDX_NOACT   = 1;
  localparam int IDX_BLOCKED = 2;
  localparam int IDX_SQUASH  = 3;
  localparam int IDX_ICWAIT  = 4;
  localparam int IDX_TLBWAIT = 5;
  localparam int IDX_TRAP    = 6;
  localparam int IDX_QUIESCE = 7;
  localparam int IDX_RETRY   = 8;
  localparam int IDX_IDLE    = 9;
endpackage

// File: rtl/fsp_classifier.sv
module fsp_classifier
  import fsp_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic                stall_i,
  input  logic                drain_pend_i,
  input  logic                no_active_i,
  input  logic [3:0]          status_i,
  input  logic [TW-1:0]       thread_count_i,
  output logic [NUM_CNT-1:0]  inc_o
);
  logic single_thr;
  assign single_thr = (thread_count_i == TW'(1));

  // priority chain: drain, empty thread set, then status
  always_comb begin
    inc_o = '0;
    if (single_thr) begin
      if (stall_i) begin
        if (drain_pend_i)     inc_o[IDX_DRAIN] = 1'b1;
        else if (no_active_i) inc_o[IDX_NOACT] = 1'b1;
        else begin
          unique case (status_i)
            ST_BLOCKED: inc_o[IDX_BLOCKED] = 1'b1;
            ST_SQUASH:  inc_o[IDX_SQUASH]  = 1'b1;
            ST_ICWAIT:  inc_o[IDX_ICWAIT]  = 1'b1;
            ST_TLBWAIT: inc_o[IDX_TLBWAIT] = 1'b1;
            ST_TRAP:    inc_o[IDX_TRAP]    = 1'b1;
            ST_QUIESCE: inc_o[IDX_QUIESCE] = 1'b1;
            ST_RETRY:   inc_o[IDX_RETRY]   = 1'b1;
            default: ;  // idle, running, bad address, unknown: uncounted
          endcase
        end
      end else if (status_i == ST_IDLE) begin
        inc_o[IDX_IDLE] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsp_sat_counter.sv
module fsp_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != CMAX) cnt_o <= cnt_o + W'(1);
  end

  a_r7_hold_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CMAX && !clr_i) |=> cnt_o == CMAX);
  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_o != CMAX) |=> cnt_o == $past(cnt_o) + W'(1));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/fsp_read_mux.sv
module fsp_read_mux
  import fsp_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic [NUM_CNT-1:0][W-1:0] cnt_i,
  input  logic [AW-1:0]             addr_i,
  output logic [W-1:0]              data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr_i == AW'(i)) data_o = cnt_i[i];
    end
  end
endmodule

// File: rtl/fetch_stall_profiler.sv
module fetch_stall_profiler
  import fsp_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TW    = 4,
  parameter int AW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic             drain_pend_i,
  input  logic             no_active_i,
  input  logic [3:0]       status_i,
  input  logic [TW-1:0]    thread_count_i,
  input  logic             clear_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic [NUM_CNT-1:0]            inc_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;

  fsp_classifier #(.TW(TW)) u_cls (
    .stall_i        (stall_i),
    .drain_pend_i   (drain_pend_i),
    .no_active_i    (no_active_i),
    .status_i       (status_i),
    .thread_count_i (thread_count_i),
    .inc_o          (inc_vec)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    fsp_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .inc_i  (inc_vec[g]),
      .cnt_o  (cnt_vec[g])
    );
  end

  fsp_read_mux #(.W(CNT_W), .AW(AW)) u_rd (
    .cnt_i  (cnt_vec),
    .addr_i (rd_addr_i),
    .data_o (rd_data_o)
  );

  a_r9_one_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_vec));
  a_r1_multi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thread_count_i != TW'(1) && !clear_i) |=> $stable(cnt_vec));
  a_r2_drain_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thread_count_i == TW'(1) && stall_i && drain_pend_i && !clear_i)
      |=> $stable(cnt_vec[NUM_CNT-1:1]));
  a_r5_badaddr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !drain_pend_i && !no_active_i && status_i == ST_BADADDR && !clear_i)
      |=> $stable(cnt_vec));
endmodule

// File: tb/tb_fetch_stall_profiler.sv
module tb_fetch_stall_profiler;
  localparam int CNT_W = 5;
  localparam int TW    = 4;
  localparam int AW    = 4;
  localparam int NCNT  = 10;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             stall_i = 1'b0, drain_pend_i = 1'b0, no_active_i = 1'b0;
  logic [3:0]       status_i = 4'd1;
  logic [TW-1:0]    thread_count_i = TW'(1);
  logic             clear_i = 1'b0;
  logic [AW-1:0]    rd_addr_i = '0;
  logic [CNT_W-1:0] rd_data_o;

  int checks = 0, errors = 0;
  int exp_cnt [NCNT];
  bit done = 0;

  always #5 clk_i = ~clk_i;

  fetch_stall_profiler #(.CNT_W(CNT_W), .TW(TW), .AW(AW)) dut (
    .clk_i, .rst_ni, .stall_i, .drain_pend_i, .no_active_i, .status_i,
    .thread_count_i, .clear_i, .rd_addr_i, .rd_data_o
  );

  // expected counter index for one cycle, -1 if none
  function automatic int classify(bit st, bit dr, bit na, logic [3:0] s, int thr);
    if (thr != 1) return -1;
    if (st) begin
      if (dr) return 0;
      if (na) return 1;
      if (s >= 4'd2 && s <= 4'd8) return int'(s);
      return -1;
    end
    if (s == 4'd0) return 9;
    return -1;
  endfunction

  task automatic step(bit st, bit dr, bit na, logic [3:0] s, int thr, bit clr);
    int idx;
    @(negedge clk_i);
    stall_i = st; drain_pend_i = dr; no_active_i = na; status_i = s;
    thread_count_i = TW'(thr); clear_i = clr;
    idx = classify(st, dr, na, s, thr);
    if (clr) begin
      for (int i = 0; i < NCNT; i++) exp_cnt[i] = 0;
    end else if (idx >= 0 && exp_cnt[idx] < CMAX) begin
      exp_cnt[idx]++;
    end
  endtask

  task automatic sweep(string tag);
    @(negedge clk_i);
    stall_i = 0; drain_pend_i = 0; no_active_i = 0; status_i = 4'd1;
    thread_count_i = TW'(1); clear_i = 0;
    for (int a = 0; a < 16; a++) begin
      int e;
      rd_addr_i = AW'(a);
      #1;
      e = (a < NCNT) ? exp_cnt[a] : 0;
      checks++;
      if (rd_data_o !== CNT_W'(e)) begin
        errors++;
        $display("FAIL %s addr %0d actual %0d expected %0d", tag, a, rd_data_o, e);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NCNT; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    sweep("R10");

    // R2: drain beats empty thread set and status
    repeat (3) step(1, 1, 1, 4'd2, 1, 0);
    sweep("R2");
    // R3: empty thread set beats status
    repeat (2) step(1, 0, 1, 4'd6, 1, 0);
    sweep("R3");
    // R4: each status code maps to its own counter
    for (int s = 2; s <= 8; s++) begin
      for (int k = 0; k < s - 1; k++) step(1, 0, 0, 4'(s), 1, 0);
    end
    sweep("R4");
    // R5: uncounted codes
    step(1, 0, 0, 4'd0, 1, 0);
    step(1, 0, 0, 4'd1, 1, 0);
    step(1, 0, 0, 4'd9, 1, 0);
    for (int s = 10; s < 16; s++) step(1, 0, 0, 4'(s), 1, 0);
    sweep("R5");
    // R6: idle without strobe counts, other statuses do not
    repeat (4) step(0, 0, 0, 4'd0, 1, 0);
    step(0, 1, 1, 4'd2, 1, 0);
    step(0, 0, 0, 4'd8, 1, 0);
    sweep("R6");
    // R1: multi-thread configurations ignored
    step(1, 1, 0, 4'd2, 2, 0);
    step(1, 0, 1, 4'd3, 0, 0);
    step(1, 0, 0, 4'd4, 3, 0);
    step(0, 0, 0, 4'd0, 4, 0);
    sweep("R1");
    // R7: saturation
    repeat (CMAX + 10) step(1, 1, 0, 4'd1, 1, 0);
    sweep("R7");
    // R8: clear wins over same-cycle increment
    step(1, 1, 0, 4'd2, 1, 1);
    sweep("R8");
    // R9: random mix
    for (int blk = 0; blk < 8; blk++) begin
      for (int n = 0; n < 300; n++) begin
        int thr;
        thr = ($urandom % 8 == 0) ? int'($urandom % 4) : 1;
        step(($urandom % 4) != 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
             4'($urandom % 16), thr, ($urandom % 200) == 0);
      end
      sweep("R9");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule